// File: doc/BRIEF.md
# Vector Prefix Detector and Element-Step Program Counter

This block keeps the current and next instruction addresses of a 64-bit core whose instruction stream may contain a 32-bit vector prefix word ahead of an ordinary instruction. It inspects the word at the current address and decides whether it is a prefix. When it is, the block pulls out the 24-bit remap field and presents the suffix word, fetched from the current address plus 4, as the instruction to decode. Otherwise it presents the word at the current address.

A 32-bit vector state register holds the maximum vector length, the active vector length (VL) and a source element step, plus three further fields that are kept but not interpreted. When a prefixed instruction with a vector destination completes one element, the block holds the program counter and advances the element step. The next instruction address is released only once the last element (step VL-1) has completed. For each register operand that the decoder flags as vector, the block adds the current element step to the register number. The step strobe marks completion of one instruction or one element. A separate load strobe writes the whole state register.

Top module: `vpfx_seq`

## Requirements
- R1: After reset, `cia_o` equals the START_PC parameter and `state_o` is all zeros.
- R2: `is_pfx_o` is 1 exactly when `word_i[31:26]` equals 6'b000001 and both `word_i[24]` and `word_i[22]` are 1.
- R3: `remap_o` is `{word_i[25], word_i[23], word_i[21:0]}`.
- R4: `fetch2_addr_o` equals `cia_o + 4`, and `insn_o` is `suffix_i` when `is_pfx_o` is 1 and `word_i` otherwise.
- R5: A step on a non-prefixed word moves `cia_o` forward by 4 and leaves `state_o` unchanged.
- R6: A step on a prefixed word while VL is 0 moves `cia_o` forward by 8 and leaves `state_o` unchanged.
- R7: A step on a prefixed word with VL nonzero, `dst_vec_i` high and the element step not equal to VL-1 keeps `cia_o` and increments the element step by 1 (7-bit wrap). All other state fields stay unchanged.
- R8: Any other step on a prefixed word with VL nonzero clears the element step to 0 and moves `cia_o` forward by 8. This covers the final element and a scalar destination.
- R9: `nia_o` always shows the value that `cia_o` takes on the next step. Without a step, `cia_o` holds.
- R10: The state register is laid out, from bit 31 down, as max length [31:25], VL [24:18], element step [17:11], destination step [10:4], subvector [3:2] and inner step [1:0]. It loads `state_ld_data_i` whenever `state_ld_i` is high. In that cycle any step strobe is ignored, so `cia_o` holds.
- R11: Operand i is taken from `op_idx_i[i*5 +: 5]` and returned on `op_reg_o[i*7 +: 7]`. It is zero-extended, plus the element step (mod 128) when `op_vec_i[i]` is set and the current word is a prefix, and unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 32 | Word fetched at the current address |
| suffix_i | input | 32 | Word fetched at the current address plus 4 |
| step_i | input | 1 | One instruction or element has completed |
| dst_vec_i | input | 1 | Destination of the current instruction is a vector |
| state_ld_i | input | 1 | Write the vector state register |
| state_ld_data_i | input | 32 | Value written to the vector state register |
| op_idx_i | input | NOPS*GPR_W | Decoded operand register numbers |
| op_vec_i | input | NOPS | Per-operand vector flag |
| cia_o | output | ADDR_W | Current instruction address |
| nia_o | output | ADDR_W | Address taken on the next step |
| fetch2_addr_o | output | ADDR_W | Address of the suffix word |
| is_pfx_o | output | 1 | Current word is a vector prefix |
| remap_o | output | 24 | Remap field of the prefix |
| insn_o | output | 32 | Instruction word to decode |
| state_o | output | 32 | Vector state register |
| op_reg_o | output | NOPS*REG_W | Element-offset operand register numbers |

## Verification
The assertions assume that `word_i` and `dst_vec_i` describe the instruction at `cia_o` and stay steady across the cycle in which a step is taken. They also assume that `step_i` is a single-cycle pulse per completed element. The bench changes the fetched word and the flags only on falling edges, and it does so before it raises the step strobe. It keeps every loaded element step at or below VL-1, so the element walk ends at VL-1 instead of wrapping through 127.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;

    localparam int WORD_W  = 32;
    localparam int STEP_W  = 7;
    localparam int REMAP_W = 24;
    localparam int MAJOR_W = 6;
    localparam logic [MAJOR_W-1:0] PFX_MAJOR = 6'b000001;

    // Vector state register, first member at bit 31
    typedef struct packed {
        logic [STEP_W-1:0] maxlen;
        logic [STEP_W-1:0] vlen;
        logic [STEP_W-1:0] src_elt;
        logic [STEP_W-1:0] dst_elt;
        logic [1:0]        sub_len;
        logic [1:0]        sub_elt;
    } vstate_t;

    typedef enum logic [1:0] {
        ACT_LINEAR = 2'd0,
        ACT_SKIP   = 2'd1,
        ACT_HOLD   = 2'd2,
        ACT_FINISH = 2'd3
    } seq_act_e;

endpackage

// File: rtl/vpfx_detect.sv
module vpfx_detect
    import vpfx_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    input  logic [WORD_W-1:0]  suffix_i,
    output logic               is_pfx_o,
    output logic [REMAP_W-1:0] remap_o,
    output logic [WORD_W-1:0]  insn_o
);

    logic major_hit;
    logic id_bits_hit;

    always_comb begin
        // Bit k in big-endian numbering is bit (31-k) here
        major_hit   = (word_i[31:26] == PFX_MAJOR);
        id_bits_hit = word_i[24] & word_i[22];
        is_pfx_o    = major_hit & id_bits_hit;
        remap_o     = {word_i[25], word_i[23], word_i[21:0]};
        insn_o      = is_pfx_o ? suffix_i : word_i;
    end

endmodule

// File: rtl/vpfx_step.sv
module vpfx_step
    import vpfx_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] cia_i,
    input  vstate_t           st_i,
    input  logic              is_pfx_i,
    input  logic              dst_vec_i,
    output seq_act_e          act_o,
    output logic [ADDR_W-1:0] nia_o,
    output logic [STEP_W-1:0] src_elt_o
);

    localparam logic [ADDR_W-1:0] INC_SHORT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] INC_LONG  = ADDR_W'(8);

    logic [STEP_W-1:0] last_elt;
    logic              vl_zero;
    logic              more_elts;

    always_comb begin
        last_elt  = st_i.vlen - STEP_W'(1);
        vl_zero   = (st_i.vlen == '0);
        more_elts = dst_vec_i && (st_i.src_elt != last_elt);

        if (!is_pfx_i)     act_o = ACT_LINEAR;
        else if (vl_zero)  act_o = ACT_SKIP;
        else if (more_elts) act_o = ACT_HOLD;
        else               act_o = ACT_FINISH;

        nia_o     = cia_i;
        src_elt_o = st_i.src_elt;
        unique case (act_o)
            ACT_LINEAR: nia_o = cia_i + INC_SHORT;
            ACT_SKIP:   nia_o = cia_i + INC_LONG;
            ACT_HOLD: begin
                nia_o     = cia_i;
                src_elt_o = st_i.src_elt + STEP_W'(1);
            end
            ACT_FINISH: begin
                nia_o     = cia_i + INC_LONG;
                src_elt_o = '0;
            end
            default: nia_o = cia_i;
        endcase
    end

endmodule

// File: rtl/vpfx_regoff.sv
module vpfx_regoff
    import vpfx_pkg::*;
#(
    parameter int NOPS  = 3,
    parameter int GPR_W = 5,
    parameter int REG_W = 7
) (
    input  logic [NOPS*GPR_W-1:0] op_idx_i,
    input  logic [NOPS-1:0]       op_vec_i,
    input  logic                  is_pfx_i,
    input  logic [STEP_W-1:0]     src_elt_i,
    output logic [NOPS*REG_W-1:0] op_reg_o
);

    localparam logic [REG_W-1:0] NO_OFFSET = '0;

    logic [REG_W-1:0] elt_ext;

    always_comb elt_ext = REG_W'(src_elt_i);

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        logic [GPR_W-1:0] idx;
        logic [REG_W-1:0] offs;
        always_comb begin
            idx  = op_idx_i[g*GPR_W +: GPR_W];
            offs = (op_vec_i[g] && is_pfx_i) ? elt_ext : NO_OFFSET;
            op_reg_o[g*REG_W +: REG_W] = REG_W'(idx) + offs;
        end
    end

endmodule

// File: rtl/vpfx_seq.sv
module vpfx_seq
    import vpfx_pkg::*;
#(
    parameter int               ADDR_W   = 64,
    parameter int               NOPS     = 3,
    parameter int               GPR_W    = 5,
    parameter int               REG_W    = 7,
    parameter logic [ADDR_W-1:0] START_PC = 64'h0000_0000_0000_1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           word_i,
    input  logic [31:0]           suffix_i,
    input  logic                  step_i,
    input  logic                  dst_vec_i,
    input  logic                  state_ld_i,
    input  logic [31:0]           state_ld_data_i,
    input  logic [NOPS*GPR_W-1:0] op_idx_i,
    input  logic [NOPS-1:0]       op_vec_i,
    output logic [ADDR_W-1:0]     cia_o,
    output logic [ADDR_W-1:0]     nia_o,
    output logic [ADDR_W-1:0]     fetch2_addr_o,
    output logic                  is_pfx_o,
    output logic [23:0]           remap_o,
    output logic [31:0]           insn_o,
    output logic [31:0]           state_o,
    output logic [NOPS*REG_W-1:0] op_reg_o
);

    localparam logic [ADDR_W-1:0] SUFFIX_OFS = ADDR_W'(4);

    typedef struct packed {
        logic [ADDR_W-1:0] cia;
        vstate_t           st;
    } seq_t;

    seq_t              seq_d;
    seq_t              seq_q;
    seq_act_e          act;
    logic [ADDR_W-1:0] nia;
    logic [STEP_W-1:0] src_elt_nxt;

    vpfx_detect u_detect (
        .word_i   (word_i),
        .suffix_i (suffix_i),
        .is_pfx_o (is_pfx_o),
        .remap_o  (remap_o),
        .insn_o   (insn_o)
    );

    vpfx_step #(.ADDR_W(ADDR_W)) u_step (
        .cia_i     (seq_q.cia),
        .st_i      (seq_q.st),
        .is_pfx_i  (is_pfx_o),
        .dst_vec_i (dst_vec_i),
        .act_o     (act),
        .nia_o     (nia),
        .src_elt_o (src_elt_nxt)
    );

    vpfx_regoff #(.NOPS(NOPS), .GPR_W(GPR_W), .REG_W(REG_W)) u_regoff (
        .op_idx_i  (op_idx_i),
        .op_vec_i  (op_vec_i),
        .is_pfx_i  (is_pfx_o),
        .src_elt_i (seq_q.st.src_elt),
        .op_reg_o  (op_reg_o)
    );

    always_comb begin
        seq_d = seq_q;
        if (state_ld_i) begin
            seq_d.st = vstate_t'(state_ld_data_i);
        end else if (step_i) begin
            seq_d.cia = nia;
            if (act == ACT_HOLD || act == ACT_FINISH) begin
                seq_d.st.src_elt = src_elt_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.cia <= START_PC;
            seq_q.st  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cia_o         = seq_q.cia;
    assign nia_o         = nia;
    assign fetch2_addr_o = seq_q.cia + SUFFIX_OFS;
    assign state_o       = seq_q.st;

endmodule

// File: rtl/vpfx_seq_chk.sv
module vpfx_seq_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic              dst_vec_i,
    input logic              state_ld_i,
    input logic [31:0]       state_ld_data_i,
    input logic [ADDR_W-1:0] cia_o,
    input logic [ADDR_W-1:0] nia_o,
    input logic              is_pfx_o,
    input logic [31:0]       state_o
);

    // R9
    cia_follows_nia_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !state_ld_i) |=> (cia_o == $past(nia_o)));

    // R9
    cia_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i || state_ld_i) |=> $stable(cia_o));

    // R5
    linear_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_pfx_o |-> (nia_o == cia_o + ADDR_W'(4)));

    // R5
    linear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pfx_o && step_i && !state_ld_i) |=> $stable(state_o));

    // R7
    elt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pfx_o && dst_vec_i && step_i && !state_ld_i && nia_o == cia_o)
        |=> (state_o[17:11] == $past(state_o[17:11]) + 7'd1));

    // R10
    state_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_ld_i |=> (state_o == $past(state_ld_data_i)));

    // R8
    finish_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pfx_o && step_i && !state_ld_i && nia_o == cia_o + ADDR_W'(8)
         && state_o[24:18] != 7'd0) |=> (state_o[17:11] == 7'd0));

endmodule

bind vpfx_seq vpfx_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .step_i          (step_i),
    .dst_vec_i       (dst_vec_i),
    .state_ld_i      (state_ld_i),
    .state_ld_data_i (state_ld_data_i),
    .cia_o           (cia_o),
    .nia_o           (nia_o),
    .is_pfx_o        (is_pfx_o),
    .state_o         (state_o)
);

// File: tb/vpfx_seq_bench.sv
module vpfx_seq_bench;

    localparam logic [63:0] START = 64'h0000_0000_0000_1000;
    localparam logic [31:0] PFX   = 32'h0540_0000;
    localparam logic [31:0] PLAIN = 32'h6000_0000;
    localparam logic [31:0] SUFX  = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] word_i, suffix_i, state_ld_data_i;
    logic        step_i, dst_vec_i, state_ld_i;
    logic [14:0] op_idx_i;
    logic [2:0]  op_vec_i;
    logic [63:0] cia_o, nia_o, fetch2_addr_o;
    logic        is_pfx_o;
    logic [23:0] remap_o;
    logic [31:0] insn_o, state_o;
    logic [20:0] op_reg_o;

    int checks   = 0;
    int failures = 0;
    logic [63:0] exp_pc;

    always #10 clk = ~clk;

    vpfx_seq #(.START_PC(START)) u_vpfx_seq (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .suffix_i(suffix_i),
        .step_i(step_i), .dst_vec_i(dst_vec_i), .state_ld_i(state_ld_i),
        .state_ld_data_i(state_ld_data_i), .op_idx_i(op_idx_i),
        .op_vec_i(op_vec_i), .cia_o(cia_o), .nia_o(nia_o),
        .fetch2_addr_o(fetch2_addr_o), .is_pfx_o(is_pfx_o),
        .remap_o(remap_o), .insn_o(insn_o), .state_o(state_o),
        .op_reg_o(op_reg_o)
    );

    function automatic logic [31:0] mk_state(input logic [6:0] mx,
                                             input logic [6:0] vl,
                                             input logic [6:0] se);
        return {mx, vl, se, 7'd0, 2'd0, 2'd0};
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_step();
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic load_state(input logic [31:0] v);
        state_ld_i = 1'b1;
        state_ld_data_i = v;
        @(negedge clk);
        state_ld_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cia", cia_o, START);
        check("R1 state", {32'd0, state_o}, 64'd0);
        exp_pc = START;
    endtask

    task automatic t_detect();
        suffix_i = SUFX;
        word_i = PFX; #1;
        check("R2 prefix", {63'd0, is_pfx_o}, 64'd1);
        check("R4 suffix insn", {32'd0, insn_o}, {32'd0, SUFX});
        check("R4 suffix addr", fetch2_addr_o, cia_o + 64'd4);
        word_i = 32'h05000000; #1;
        check("R2 no bit22", {63'd0, is_pfx_o}, 64'd0);
        check("R4 plain insn", {32'd0, insn_o}, 64'h0500_0000);
        word_i = 32'h04400000; #1;
        check("R2 no bit24", {63'd0, is_pfx_o}, 64'd0);
        word_i = 32'h09400000; #1;
        check("R2 major 2", {63'd0, is_pfx_o}, 64'd0);
        word_i = 32'h07C12345; #1;
        check("R2 remap word", {63'd0, is_pfx_o}, 64'd1);
        check("R3 remap", {40'd0, remap_o}, 64'hC12345);
        @(negedge clk);
    endtask

    task automatic t_linear();
        word_i = PLAIN; dst_vec_i = 1'b1;
        for (int i = 0; i < 2; i++) begin
            pulse_step();
            exp_pc += 64'd4;
            check("R5 pc+4", cia_o, exp_pc);
            check("R5 state", {32'd0, state_o}, 64'd0);
        end
        check("R9 hold", cia_o, exp_pc);
    endtask

    task automatic t_skip();
        word_i = PFX; dst_vec_i = 1'b1; #1;
        check("R9 nia skip", nia_o, exp_pc + 64'd8);
        pulse_step();
        exp_pc += 64'd8;
        check("R6 pc+8", cia_o, exp_pc);
        check("R6 state", {32'd0, state_o}, 64'd0);
    endtask

    task automatic t_loop();
        load_state(mk_state(7'd8, 7'd3, 7'd0));
        check("R10 load", {32'd0, state_o}, {32'd0, mk_state(7'd8, 7'd3, 7'd0)});
        word_i = PFX; dst_vec_i = 1'b1; #1;
        check("R9 nia hold", nia_o, exp_pc);
        pulse_step();
        check("R7 pc held", cia_o, exp_pc);
        check("R7 step1", {32'd0, state_o}, {32'd0, mk_state(7'd8, 7'd3, 7'd1)});
        pulse_step();
        check("R7 step2", {32'd0, state_o}, {32'd0, mk_state(7'd8, 7'd3, 7'd2)});
        check("R9 nia last", nia_o, exp_pc + 64'd8);
        pulse_step();
        exp_pc += 64'd8;
        check("R8 pc+8", cia_o, exp_pc);
        check("R8 cleared", {32'd0, state_o}, {32'd0, mk_state(7'd8, 7'd3, 7'd0)});
    endtask

    task automatic t_scalar_dst();
        load_state(mk_state(7'd8, 7'd3, 7'd1));
        word_i = PFX; dst_vec_i = 1'b0;
        pulse_step();
        exp_pc += 64'd8;
        check("R8 scalar pc", cia_o, exp_pc);
        check("R8 scalar clr", {32'd0, state_o}, {32'd0, mk_state(7'd8, 7'd3, 7'd0)});
    endtask

    task automatic t_regoff();
        load_state(mk_state(7'd8, 7'd8, 7'd5));
        op_idx_i = {5'd10, 5'd2, 5'd31};
        op_vec_i = 3'b101;
        word_i = PFX; #1;
        check("R11 vec op0", {57'd0, op_reg_o[6:0]}, 64'd36);
        check("R11 scalar op1", {57'd0, op_reg_o[13:7]}, 64'd2);
        check("R11 vec op2", {57'd0, op_reg_o[20:14]}, 64'd15);
        word_i = PLAIN; #1;
        check("R11 plain op0", {57'd0, op_reg_o[6:0]}, 64'd31);
        @(negedge clk);
    endtask

    task automatic t_load_prio();
        word_i = PLAIN;
        step_i = 1'b1;
        load_state(mk_state(7'd4, 7'd2, 7'd1));
        step_i = 1'b0;
        check("R10 step ignored", cia_o, exp_pc);
        check("R10 new state", {32'd0, state_o}, {32'd0, mk_state(7'd4, 7'd2, 7'd1)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; word_i = PLAIN; suffix_i = SUFX; step_i = 1'b0;
        dst_vec_i = 1'b0; state_ld_i = 1'b0; state_ld_data_i = '0;
        op_idx_i = '0; op_vec_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_detect();
        t_linear();
        t_skip();
        t_loop();
        t_scalar_dst();
        t_regoff();
        t_load_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule